// File: doc/BRIEF.md
# Bus-Programmed Nonvolatile Trim Register

This block is a two-wire serial (I2C) slave that holds the 7-bit code driving a current-sink DAC. The output sink current scales linearly with the code: each step is one 128th of full scale. A host trims the code over the bus while it watches the panel, then commits the chosen value to a nonvolatile cell. After every power-up or reset the block drives the committed code again, with no bus traffic needed.

The slave answers only to its hard-wired 7-bit address 1001111, so it takes 0x9E as the write byte and 0x9F as the read byte. A write carries one selector byte and then one data byte. The selector picks between a live-only update and a live update plus commit. A commit is allowed only while the unlock input is high. The unlock pin is meant to have a pull-down on the board, so programming is blocked unless something drives it high. A commit starts a long busy window that models the storage write time. While that window is open the slave does not acknowledge its address, so the host can poll until the write has finished.

SCL and SDA are synchronised to the system clock and passed through a 3-sample majority filter before any START, STOP or bit edge is decoded. A pulse lasting one clock period is therefore ignored.

Top module: `trim_i2c_nvtrim`

## Requirements
- R1: The slave acknowledges only the address bytes 0x9E (write) and 0x9F (read). After any other address it never drives SDA until the next START.
- R2: Selector byte 0x00 followed by a data byte sets dac_code to data bits 6..0 at once. Data bit 7 is ignored. The selector and data bytes are both acknowledged.
- R3: Selector byte 0x80 with nv_unlock high sets dac_code to data bits 6..0 and writes that value into the nonvolatile cell.
- R4: Selector byte 0x80 with nv_unlock low acknowledges the data byte and then discards it. Neither dac_code nor the stored value changes.
- R5: Any selector byte other than 0x00 or 0x80 is acknowledged, and so is its data byte. The data byte is then discarded.
- R6: For WR_CYCLES clock cycles after a commit, the address byte is not acknowledged. After that window it is acknowledged again.
- R7: While rst_n is low, and after it is released, dac_code equals the stored value. A live-only value is lost at reset. The stored value survives reset.
- R8: A read returns one byte {0, dac_code} per master ACK. A master NACK ends the read, and the slave releases SDA.
- R9: A pulse of one clock period on SCL or SDA is ignored by the bus decoder.
- R10: A write accepts only one data byte. A further byte before STOP is not acknowledged and has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; bus inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; reloads the stored code |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low (open-drain driver enable) |
| nv_unlock | input | 1 | High permits nonvolatile commits |
| dac_code | output | CODE_W | Live code for the current-sink DAC |

## Verification
The case that needs care is the end of the commit busy window arriving close to the acknowledge decision for a polling address byte. The bench provokes it by polling with bare address transactions right after a commit. For each poll it measures the cycles between the falling edge of the last data bit and the falling edge of the last address bit. A poll well inside the window must be refused and a poll well past it must be accepted. A second coincidence is a glitch landing on a live bit transfer. A single-cycle SCL pulse inside a low phase, and a single-cycle SDA dip inside a high phase, are both injected into data bytes. The written code must arrive intact.

// File: rtl/trim_i2c_pkg.sv
package trim_i2c_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_SEL,
      ST_SEL_ACK,
      ST_DATA,
      ST_DATA_ACK,
      ST_RD,
      ST_RD_ACK
   } slv_state_t;

   typedef struct packed {
      logic rise;
      logic fall;
      logic start;
      logic stop;
      logic sda;
   } bus_ev_t;

endpackage

// File: rtl/trim_i2c_filter.sv
module trim_i2c_filter #(
   parameter bit MAJORITY = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic clean
);
   logic [1:0] sync_q;
   logic       clean_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sync_q <= 2'b11;
      else        sync_q <= {sync_q[0], raw};
   end

   generate
      if (MAJORITY) begin : g_vote
         logic [2:0] win_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               win_q   <= 3'b111;
               clean_q <= 1'b1;
            end else begin
               win_q   <= {win_q[1:0], sync_q[1]};
               clean_q <= (win_q[0] & win_q[1]) | (win_q[0] & win_q[2]) |
                          (win_q[1] & win_q[2]);
            end
         end
      end else begin : g_pass
         always_ff @(posedge clk) begin
            if (!rst_n) clean_q <= 1'b1;
            else        clean_q <= sync_q[1];
         end
      end
   endgenerate

   assign clean = clean_q;
endmodule

// File: rtl/trim_i2c_events.sv
module trim_i2c_events
   import trim_i2c_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    scl_f,
   input  logic    sda_f,
   output bus_ev_t ev
);
   logic scl_p, sda_p;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_f;
         sda_p <= sda_f;
      end
   end

   always_comb begin
      ev.rise  = scl_f & ~scl_p;
      ev.fall  = ~scl_f & scl_p;
      ev.start = scl_f & scl_p & sda_p & ~sda_f;
      ev.stop  = scl_f & scl_p & ~sda_p & sda_f;
      ev.sda   = sda_f;
   end
endmodule

// File: rtl/trim_nv_cell.sv
module trim_nv_cell #(
   parameter int              CODE_W    = 7,
   parameter int              WR_CYCLES = 10_000_000,
   parameter logic [CODE_W-1:0] INIT_CODE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CODE_W-1:0] wr_data,
   output logic [CODE_W-1:0] rd_data,
   output logic              busy
);
   localparam int CNT_W = $clog2(WR_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WR_CYCLES);

   logic [CODE_W-1:0] cell_q;
   logic [CNT_W-1:0]  left_q;

   // storage contents survive rst_n; only the power-on value is preset
   initial cell_q = INIT_CODE;

   always @(posedge clk) begin
      if (wr_en) cell_q <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)            left_q <= '0;
      else if (wr_en)        left_q <= CNT_LOAD;
      else if (left_q != '0) left_q <= left_q - 1'b1;
   end

   assign rd_data = cell_q;
   assign busy    = (left_q != '0);
endmodule

// File: rtl/trim_i2c_slave.sv
module trim_i2c_slave
   import trim_i2c_pkg::*;
#(
   parameter int          CODE_W  = 7,
   parameter logic [6:0]  DEV_ID  = 7'h4F,
   parameter logic [7:0]  SEL_LIVE = 8'h00,
   parameter logic [7:0]  SEL_SAVE = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_ev_t           ev,
   input  logic              busy,
   input  logic              unlock,
   input  logic [CODE_W-1:0] live_code,
   output logic              sda_oe,
   output logic              apply,
   output logic              commit,
   output logic [CODE_W-1:0] new_code
);
   slv_state_t  state_q;
   logic [3:0]  cnt_q;
   logic [7:0]  sh_q, sel_q, tx_q;
   logic        oe_q, apply_q, commit_q;
   logic [CODE_W-1:0] code_q;
   logic [7:0]  rd_byte;

   assign rd_byte = 8'(live_code);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cnt_q    <= '0;
         sh_q     <= '0;
         sel_q    <= '0;
         tx_q     <= '0;
         oe_q     <= 1'b0;
         apply_q  <= 1'b0;
         commit_q <= 1'b0;
         code_q   <= '0;
      end else begin
         apply_q  <= 1'b0;
         commit_q <= 1'b0;
         if (ev.stop) begin
            state_q <= ST_IDLE;
            oe_q    <= 1'b0;
         end else if (ev.start) begin
            state_q <= ST_DEV;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
         end else begin
            case (state_q)
               ST_DEV, ST_SEL, ST_DATA: begin
                  if (ev.rise) begin
                     sh_q  <= {sh_q[6:0], ev.sda};
                     cnt_q <= cnt_q + 1'b1;
                  end else if (ev.fall && cnt_q == 4'd8) begin
                     if (state_q == ST_DEV) begin
                        if (sh_q[7:1] == DEV_ID && !busy) begin
                           oe_q    <= 1'b1;
                           state_q <= ST_DEV_ACK;
                           sel_q   <= {7'd0, sh_q[0]};
                        end else begin
                           state_q <= ST_IDLE;
                        end
                     end else if (state_q == ST_SEL) begin
                        sel_q   <= sh_q;
                        oe_q    <= 1'b1;
                        state_q <= ST_SEL_ACK;
                     end else begin
                        oe_q    <= 1'b1;
                        state_q <= ST_DATA_ACK;
                        code_q  <= sh_q[CODE_W-1:0];
                        if (sel_q == SEL_LIVE) begin
                           apply_q <= 1'b1;
                        end else if (sel_q == SEL_SAVE && unlock) begin
                           apply_q  <= 1'b1;
                           commit_q <= 1'b1;
                        end
                     end
                  end
               end
               ST_DEV_ACK: begin
                  if (ev.fall) begin
                     cnt_q <= '0;
                     if (sel_q[0]) begin
                        tx_q    <= rd_byte;
                        oe_q    <= ~rd_byte[7];
                        state_q <= ST_RD;
                     end else begin
                        oe_q    <= 1'b0;
                        state_q <= ST_SEL;
                     end
                  end
               end
               ST_SEL_ACK: begin
                  if (ev.fall) begin
                     oe_q    <= 1'b0;
                     cnt_q   <= '0;
                     state_q <= ST_DATA;
                  end
               end
               ST_DATA_ACK: begin
                  if (ev.fall) begin
                     oe_q    <= 1'b0;
                     state_q <= ST_IDLE;
                  end
               end
               ST_RD: begin
                  if (ev.rise) begin
                     cnt_q <= cnt_q + 1'b1;
                  end else if (ev.fall) begin
                     if (cnt_q == 4'd8) begin
                        oe_q    <= 1'b0;
                        state_q <= ST_RD_ACK;
                     end else begin
                        tx_q <= {tx_q[6:0], 1'b0};
                        oe_q <= ~tx_q[6];
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (ev.rise && ev.sda) begin
                     state_q <= ST_IDLE;
                  end else if (ev.fall) begin
                     tx_q    <= rd_byte;
                     oe_q    <= ~rd_byte[7];
                     cnt_q   <= '0;
                     state_q <= ST_RD;
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign sda_oe   = oe_q;
   assign apply    = apply_q;
   assign commit   = commit_q;
   assign new_code = code_q;
endmodule

// File: rtl/trim_i2c_nvtrim.sv
module trim_i2c_nvtrim
   import trim_i2c_pkg::*;
#(
   parameter int                CODE_W    = 7,
   parameter logic [6:0]        DEV_ID    = 7'h4F,
   parameter logic [7:0]        SEL_LIVE  = 8'h00,
   parameter logic [7:0]        SEL_SAVE  = 8'h80,
   parameter int                WR_CYCLES = 10_000_000,
   parameter logic [CODE_W-1:0] INIT_CODE = '0,
   parameter bit                MAJORITY  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic              nv_unlock,
   output logic [CODE_W-1:0] dac_code
);
   generate
      if (CODE_W < 1 || CODE_W > 8) begin : g_bad_width
         $error("CODE_W must lie in 1..8");
      end
      if (WR_CYCLES < 1) begin : g_bad_delay
         $error("WR_CYCLES must be at least 1");
      end
      if (SEL_LIVE == SEL_SAVE) begin : g_bad_sel
         $error("selector codes must differ");
      end
   endgenerate

   logic              scl_f, sda_f;
   bus_ev_t           ev_w;
   logic              apply_w, commit_w, busy_w;
   logic [CODE_W-1:0] data_w, stored_w, live_q;

   trim_i2c_filter #(.MAJORITY(MAJORITY)) u_scl_filt (
      .clk(clk), .rst_n(rst_n), .raw(scl_i), .clean(scl_f));

   trim_i2c_filter #(.MAJORITY(MAJORITY)) u_sda_filt (
      .clk(clk), .rst_n(rst_n), .raw(sda_i), .clean(sda_f));

   trim_i2c_events u_events (
      .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f), .ev(ev_w));

   trim_i2c_slave #(
      .CODE_W(CODE_W), .DEV_ID(DEV_ID),
      .SEL_LIVE(SEL_LIVE), .SEL_SAVE(SEL_SAVE)
   ) u_slave (
      .clk(clk), .rst_n(rst_n), .ev(ev_w), .busy(busy_w),
      .unlock(nv_unlock), .live_code(live_q), .sda_oe(sda_oe),
      .apply(apply_w), .commit(commit_w), .new_code(data_w));

   trim_nv_cell #(
      .CODE_W(CODE_W), .WR_CYCLES(WR_CYCLES), .INIT_CODE(INIT_CODE)
   ) u_cell (
      .clk(clk), .rst_n(rst_n), .wr_en(commit_w), .wr_data(data_w),
      .rd_data(stored_w), .busy(busy_w));

   always_ff @(posedge clk) begin
      if (!rst_n)       live_q <= stored_w;
      else if (apply_w) live_q <= data_w;
   end

   assign dac_code = live_q;
endmodule

// File: rtl/trim_i2c_nvtrim_chk.sv
module trim_i2c_nvtrim_chk #(
   parameter int CODE_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              nv_unlock,
   input logic [CODE_W-1:0] dac_code,
   input logic              apply,
   input logic              commit,
   input logic              nv_busy,
   input logic [CODE_W-1:0] stored
);
   assert_restore_on_reset_R7: assert property (@(posedge clk)
      !rst_n |=> (dac_code == $past(stored)));

   assert_commit_needs_unlock_R4: assert property (@(posedge clk)
      disable iff (!rst_n) commit |-> nv_unlock);

   assert_no_commit_while_busy_R6: assert property (@(posedge clk)
      disable iff (!rst_n) commit |-> !nv_busy);

   assert_busy_after_commit_R3: assert property (@(posedge clk)
      disable iff (!rst_n) commit |=> (nv_busy && stored == dac_code));

   assert_store_only_on_commit_R3: assert property (@(posedge clk)
      disable iff (!rst_n) (stored != $past(stored)) |-> $past(commit));

   assert_code_only_on_write_R2: assert property (@(posedge clk)
      disable iff (!rst_n)
      ($past(rst_n) && dac_code != $past(dac_code)) |-> $past(apply));
endmodule

bind trim_i2c_nvtrim trim_i2c_nvtrim_chk #(.CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .nv_unlock(nv_unlock), .dac_code(dac_code),
   .apply(apply_w), .commit(commit_w), .nv_busy(busy_w), .stored(stored_w));

// File: tb/trim_i2c_nvtrim_test.sv
module trim_i2c_nvtrim_test;
   localparam int         WRC  = 1500;
   localparam int         Q    = 10;
   localparam logic [6:0] INIT = 7'h2A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic unlock = 1'b0;
   logic sda_oe;
   logic [6:0] dac_code;
   wire  sda_bus = sda_m & ~sda_oe;

   int cyc = 0;
   int nchk = 0;
   int nerr = 0;
   int last_fall = 0;
   int busy_until = 0;
   logic [6:0] exp_live = INIT;
   logic [6:0] exp_stored = INIT;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   trim_i2c_nvtrim #(.WR_CYCLES(WRC), .INIT_CODE(INIT)) uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_oe(sda_oe), .nv_unlock(unlock), .dac_code(dac_code));

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq(Q);
      scl_m = 1'b1; wq(Q);
      sda_m = 1'b0; wq(Q);
      scl_m = 1'b0; wq(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(Q);
      scl_m = 1'b1; wq(Q);
      sda_m = 1'b1; wq(2 * Q);
   endtask

   // gmode 1: single-cycle SCL pulse in the low phase of the first bit
   // gmode 2: single-cycle SDA dip in the high phase of the first bit
   task automatic send_byte(input logic [7:0] b, input int gmode, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i];
         if (i == 7 && gmode == 1) begin
            wq(3); scl_m = 1'b1; wq(1); scl_m = 1'b0; wq(Q - 4);
         end else begin
            wq(Q);
         end
         scl_m = 1'b1;
         if (i == 7 && gmode == 2) begin
            wq(5); sda_m = 1'b0; wq(1); sda_m = b[i]; wq(2 * Q - 6);
         end else begin
            wq(2 * Q);
         end
         scl_m = 1'b0;
         if (i == 0) last_fall = cyc;
         wq(Q);
      end
      sda_m = 1'b1; wq(Q);
      scl_m = 1'b1; wq(Q);
      ack = ~sda_bus;
      wq(Q);
      scl_m = 1'b0; wq(Q);
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; wq(Q);
         scl_m = 1'b1; wq(Q);
         b[i] = sda_bus;
         wq(Q);
         scl_m = 1'b0; wq(Q);
      end
      sda_m = ~mack; wq(Q);
      scl_m = 1'b1; wq(2 * Q);
      scl_m = 1'b0; wq(Q);
      sda_m = 1'b1;
   endtask

   task automatic wait_free();
      while (cyc < busy_until) @(negedge clk);
   endtask

   task automatic write_txn(input logic [7:0] sel, input logic [7:0] data,
                            input int gmode, input bit extra,
                            output logic [3:0] acks);
      logic a;
      acks = '0;
      wait_free();
      bus_start();
      send_byte(8'h9E, 0, a); acks[0] = a;
      if (a) begin
         send_byte(sel, 0, a); acks[1] = a;
         send_byte(data, gmode, a); acks[2] = a;
         if (sel == 8'h80 && unlock) busy_until = last_fall + WRC + 40;
         if (extra) begin
            send_byte(8'h70, 0, a); acks[3] = a;
         end
      end
      bus_stop();
      wq(4);
   endtask

   task automatic read_chk(input int nbytes, input string tag);
      logic a;
      logic [7:0] b;
      wait_free();
      bus_start();
      send_byte(8'h9F, 0, a);
      chk({tag, " read address ack"}, a, 1);
      for (int k = 0; k < nbytes; k++) begin
         recv_byte(k != nbytes - 1, b);
         chk({tag, " read byte"}, b, {1'b0, exp_live});
      end
      chk({tag, " SDA released after master NACK"}, sda_oe, 0);
      bus_stop();
      wq(4);
   endtask

   task automatic do_reset(input string tag);
      rst_n = 1'b0;
      wq(3);
      chk({tag, " code during reset"}, dac_code, exp_stored);
      rst_n = 1'b1;
      wq(3);
      exp_live = exp_stored;
      chk({tag, " code after reset"}, dac_code, exp_stored);
   endtask

   function automatic logic [6:0] model_code(input logic [7:0] sel, input logic [7:0] d,
                                            input logic ul, input logic [6:0] cur);
      if (sel == 8'h00 || (sel == 8'h80 && ul)) return d[6:0];
      return cur;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired actual=%0d expected=<200000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      logic [3:0] acks;
      logic a;
      int el;
      int tc;
      bit got;
      void'($urandom(32'd20061));
      wq(3);
      chk("R7 power-up code during reset", dac_code, INIT);
      chk("R1 SDA idle in reset", sda_oe, 0);
      rst_n = 1'b1;
      wq(4);
      chk("R7 power-up code", dac_code, INIT);

      read_chk(1, "R8 single");
      read_chk(3, "R8 multi");

      wait_free();
      bus_start(); send_byte(8'hA0, 0, a); bus_stop();
      chk("R1 foreign address not acked", a, 0);
      bus_start(); send_byte(8'h9C, 0, a); bus_stop();
      chk("R1 neighbouring address not acked", a, 0);
      chk("R1 code unchanged", dac_code, exp_live);

      write_txn(8'h00, 8'hD5, 0, 0, acks);
      exp_live = 7'h55;
      chk("R1 write address ack", acks[0], 1);
      chk("R2 selector and data ack", acks[2:1], 2'b11);
      chk("R2 live write, bit7 ignored", dac_code, exp_live);

      write_txn(8'h33, 8'h11, 0, 0, acks);
      chk("R5 unknown selector acks", acks[2:0], 3'b111);
      chk("R5 data discarded", dac_code, exp_live);

      unlock = 1'b0;
      write_txn(8'h80, 8'h12, 0, 0, acks);
      chk("R4 locked data acked", acks[2], 1);
      chk("R4 locked write discarded", dac_code, exp_live);
      do_reset("R4 R7 locked storage unchanged");

      unlock = 1'b1;
      write_txn(8'h80, 8'h3C, 0, 0, acks);
      exp_live = 7'h3C;
      exp_stored = 7'h3C;
      chk("R3 commit updates live code", dac_code, exp_live);
      tc = last_fall;
      got = 0;
      for (int p = 0; p < 12 && !got; p++) begin
         bus_start(); send_byte(8'h9E, 0, a); bus_stop();
         el = last_fall - tc;
         if (el < WRC - 10) chk("R6 address refused while busy", a, 0);
         else if (el > WRC + 10) chk("R6 address accepted after busy", a, 1);
         if (a) got = 1;
      end
      chk("R6 busy window ends", got, 1);
      busy_until = 0;
      do_reset("R3 R7 committed code restored");
      unlock = 1'b0;

      write_txn(8'h00, 8'h07, 0, 1, acks);
      exp_live = 7'h07;
      chk("R10 extra byte not acked", acks[3], 0);
      chk("R10 code from first data byte", dac_code, exp_live);

      write_txn(8'h00, 8'h4B, 1, 0, acks);
      exp_live = 7'h4B;
      chk("R9 SCL pulse rejected", dac_code, exp_live);
      write_txn(8'h00, 8'hDA, 2, 0, acks);
      exp_live = 7'h5A;
      chk("R9 SDA dip rejected", dac_code, exp_live);
      chk("R9 data byte still acked", acks[2], 1);

      for (int it = 0; it < 36; it++) begin
         int kind;
         logic [7:0] sel;
         logic [7:0] d;
         kind = int'($urandom_range(0, 9));
         d = 8'($urandom);
         unlock = 1'($urandom);
         if (kind < 6) begin
            sel = (kind < 3) ? 8'h00 : (kind < 5) ? 8'h80 : 8'($urandom);
            write_txn(sel, d, 0, 0, acks);
            chk("R2 R3 R4 R5 random write ack", acks[2:0], 3'b111);
            exp_live = model_code(sel, d, unlock, exp_live);
            if (sel == 8'h80 && unlock) exp_stored = d[6:0];
            chk("R2 R3 R4 R5 random write code", dac_code, exp_live);
         end else if (kind < 8) begin
            read_chk(1 + int'($urandom_range(0, 1)), "R8 random");
         end else begin
            do_reset("R7 random reset");
         end
      end
      do_reset("R3 R7 final restore");

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule